// File: doc/BRIEF.md
# Serial FIFO trigger-level controller

This block holds the byte queues between a CPU and the shift engines of an asynchronous serial port. The outgoing queue is filled by the CPU and drained by the transmit shifter. The incoming queue is filled by the receive shifter and drained by the CPU. Each queue has 16 entries and reports its occupancy.

An 8-bit control register selects two fill thresholds from fixed 2-bit codes. It also holds a flush bit for each queue and a loopback bit. A second register address returns three sticky status flags:
- the receive-threshold flag,
- the transmit-threshold flag,
- the receive-overrun flag.

Each flag is a two-state machine with states `FLAG_LOW` and `FLAG_HIGH`. The *raise* transition goes from `FLAG_LOW` to `FLAG_HIGH` when the flag's condition holds at a clock edge. The *clear* transition goes from `FLAG_HIGH` to `FLAG_LOW` when the CPU writes 0 to that status bit and the condition is false in the same cycle. In every other case the flag keeps its state. The two threshold flags are re-evaluated against the queue counts on every clock.

In loopback mode, each byte the transmit shifter pops is also written into the receive queue one cycle later. Pushes from the receive shifter are ignored while loopback is on.

Top module: `sfifo_trig_ctrl`

## Requirements
- R1: The control register reads back all 8 written bits, including bit 3, which controls nothing. It is 0x00 after reset. It returns to 0x00 on the cycle after `standby` is high, and `standby` takes priority over a write in the same cycle.
- R2: Control bits 7:6 pick the receive threshold: 00→1, 01→4, 10→8, 11→14 bytes. Status bit 0 goes high one cycle after the receive count is at or above the threshold.
- R3: Control bits 5:4 pick the transmit threshold: 00→8, 01→4, 10→2, 11→1 bytes. Status bit 1 goes high one cycle after the transmit count is at or below the threshold. It therefore rises just after reset, when the queue is empty and the threshold is 8.
- R4: A set flag stays set until the CPU writes 0 to its status bit (address 1). That clear has no effect while the flag's condition still holds. Writing 1 to a status bit has no effect.
- R5: Each queue returns bytes in the order they were pushed. It holds up to 16 bytes, and its count output reports how many bytes it holds.
- R6: While control bit 2 is 1, the transmit queue is empty and ignores pushes. While control bit 1 is 1, the receive queue does the same.
- R7: While control bit 0 is 1, every byte popped from a non-empty transmit queue enters the receive queue, and `rx_push` from outside has no effect.
- R8: A push into a full receive queue drops the byte and sets status bit 2. Writing 0 to status bit 2 clears it.
- R9: A pop from an empty queue leaves that queue's read-data output and count unchanged.
- R10: The status register (address 1) reads {5'b0, overrun, transmit flag, receive flag}, with the receive flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Standby entry; clears the control register |
| reg_wr | input | 1 | CPU register write strobe |
| reg_addr | input | 1 | Register select: 0 = control, 1 = status |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Selected register contents |
| tx_push | input | 1 | CPU writes a byte into the transmit queue |
| tx_wdata | input | DW | Byte to queue for transmission |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_rdata | output | DW | Last byte popped from the transmit queue |
| tx_level | output | 5 | Transmit queue occupancy |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_wdata | input | DW | Received byte |
| rx_pop | input | 1 | CPU takes a received byte |
| rx_rdata | output | DW | Last byte popped from the receive queue |
| rx_level | output | 5 | Receive queue occupancy |
| rx_thresh_flag | output | 1 | Sticky receive-threshold flag |
| tx_thresh_flag | output | 1 | Sticky transmit-threshold flag |
| rx_ovr_flag | output | 1 | Sticky receive-overrun flag |

## Verification
The hardest case to reach is a refused clear. The clear write must land while the queue count still meets the threshold, and the flag must then stay high after the queue drains below it. The bench fills the receive queue exactly to each of the four thresholds, writes 0 to the flag, and pops the queue empty. It then shows that the flag is still set before a second clear succeeds.

For the transmit side, the bench fills the queue to 16 and pops it down one byte at a time. The flag must stay low at one byte above the threshold and rise at the threshold itself. For loopback, the bench queues bytes for transmit, pops them, and compares what reaches the receive queue against its own scoreboard. An external receive push is injected at the same time to show it is ignored.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    typedef enum logic [0:0] {
        FLAG_LOW  = 1'b0,
        FLAG_HIGH = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic [1:0] rx_sel;
        logic [1:0] tx_sel;
        logic       aux_en;
        logic       tx_flush;
        logic       rx_flush;
        logic       loop_en;
    } ctrl_t;

    function automatic logic [7:0] rx_threshold(input logic [1:0] sel);
        logic [7:0] lvl;
        unique case (sel)
            2'b00: lvl = 8'd1;
            2'b01: lvl = 8'd4;
            2'b10: lvl = 8'd8;
            2'b11: lvl = 8'd14;
        endcase
        return lvl;
    endfunction

    function automatic logic [7:0] tx_threshold(input logic [1:0] sel);
        logic [7:0] lvl;
        unique case (sel)
            2'b00: lvl = 8'd8;
            2'b01: lvl = 8'd4;
            2'b10: lvl = 8'd2;
            2'b11: lvl = 8'd1;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/sfifo_buffer.sv
module sfifo_buffer #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          full, empty, do_push, do_pop;

    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            dout  <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop) begin
                rptr <= rptr + 1'b1;
                dout <= mem[rptr];
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R5
    cnt_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop && !flush) |=> count == $past(count) + CW'(1));

    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> $stable(dout));

endmodule

// File: rtl/sfifo_flag.sv
module sfifo_flag
    import sfifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic clr,
    output logic flag
);

    flag_state_e state, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FLAG_LOW;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            FLAG_LOW:  if (cond)         state_n = FLAG_HIGH;
            FLAG_HIGH: if (clr && !cond) state_n = FLAG_LOW;
        endcase
    end

    always_comb begin
        flag = (state == FLAG_HIGH);
    end

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R4
    flag_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && cond) |=> flag);

endmodule

// File: rtl/sfifo_trig_ctrl.sv
module sfifo_trig_ctrl
    import sfifo_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic          reg_wr,
    input  logic          reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_wdata,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_rdata,
    output logic [CW-1:0] tx_level,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_wdata,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_rdata,
    output logic [CW-1:0] rx_level,
    output logic          rx_thresh_flag,
    output logic          tx_thresh_flag,
    output logic          rx_ovr_flag
);

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;
    localparam int   NFLAG     = 3;

    ctrl_t           ctrl_q;
    logic            loop_pend_q;
    logic            rx_in_push;
    logic [DW-1:0]   rx_in_data;
    logic            rx_full;
    logic [7:0]      rx_lvl, tx_lvl;
    logic [NFLAG-1:0] f_cond, f_clr, f_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            ctrl_q <= '0;
        else if (standby)                      ctrl_q <= '0;
        else if (reg_wr && reg_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(reg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) loop_pend_q <= 1'b0;
        else        loop_pend_q <= ctrl_q.loop_en && tx_pop
                                   && (tx_level != '0) && !ctrl_q.tx_flush;
    end

    always_comb begin
        rx_in_push = ctrl_q.loop_en ? loop_pend_q : rx_push;
        rx_in_data = ctrl_q.loop_en ? tx_rdata    : rx_wdata;
        rx_full    = (rx_level == CW'(DEPTH));
        rx_lvl     = rx_threshold(ctrl_q.rx_sel);
        tx_lvl     = tx_threshold(ctrl_q.tx_sel);
        f_cond[0]  = int'(rx_level) >= int'(rx_lvl);
        f_cond[1]  = int'(tx_level) <= int'(tx_lvl);
        f_cond[2]  = rx_in_push && rx_full && !ctrl_q.rx_flush;
    end

    sfifo_buffer #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (ctrl_q.tx_flush),
        .push  (tx_push),
        .din   (tx_wdata),
        .pop   (tx_pop),
        .dout  (tx_rdata),
        .count (tx_level)
    );

    sfifo_buffer #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (ctrl_q.rx_flush),
        .push  (rx_in_push),
        .din   (rx_in_data),
        .pop   (rx_pop),
        .dout  (rx_rdata),
        .count (rx_level)
    );

    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        assign f_clr[k] = reg_wr && (reg_addr == ADDR_STAT) && !reg_wdata[k];
        sfifo_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .cond  (f_cond[k]),
            .clr   (f_clr[k]),
            .flag  (f_out[k])
        );
    end

    always_comb begin
        rx_thresh_flag = f_out[0];
        tx_thresh_flag = f_out[1];
        rx_ovr_flag    = f_out[2];
        if (reg_addr == ADDR_STAT) reg_rdata = {5'b0, f_out};
        else                       reg_rdata = ctrl_q;
    end

    // R1
    stby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> ctrl_q == '0);

    // R2
    rx_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rx_level) >= int'(rx_threshold(ctrl_q.rx_sel))) |=> rx_thresh_flag);

    // R3
    tx_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_level) <= int'(tx_threshold(ctrl_q.tx_sel))) |=> tx_thresh_flag);

    // R7
    loop_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.loop_en && rx_push && !loop_pend_q && !rx_pop && !ctrl_q.rx_flush)
        |=> rx_level == $past(rx_level));

    // R8
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_in_push && rx_full && !ctrl_q.rx_flush && !rx_pop) |=> (rx_ovr_flag && rx_full));

endmodule

// File: tb/sfifo_trig_ctrl_test.sv
module sfifo_trig_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_wdata = '0, rx_wdata = '0;
    logic [7:0] tx_rdata, rx_rdata;
    logic [4:0] tx_level, rx_level;
    logic       rx_thresh_flag, tx_thresh_flag, rx_ovr_flag;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    bit m_txflush = 0, m_rxflush = 0, m_loop = 0;
    bit tx_mon = 0, rx_mon = 0;

    always #5 clk = ~clk;

    sfifo_trig_ctrl uut (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata), .tx_level(tx_level),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_level(rx_level),
        .rx_thresh_flag(rx_thresh_flag), .tx_thresh_flag(tx_thresh_flag), .rx_ovr_flag(rx_ovr_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 1'b0) begin
            m_loop = d[0]; m_rxflush = d[1]; m_txflush = d[2];
            if (d[1]) rxq.delete();
            if (d[2]) txq.delete();
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_push = 1'b1; tx_wdata = b;
        if (!m_txflush && txq.size() < 16) txq.push_back(b);
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_push = 1'b1; rx_wdata = b;
        if (!m_rxflush && !m_loop && rxq.size() < 16) rxq.push_back(b);
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pop_tx();
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    // Scoreboard monitor: note which pops the model expects to return data
    always @(posedge clk) begin
        rx_mon <= rx_pop && (rxq.size() != 0) && !m_rxflush;
        tx_mon <= tx_pop && (txq.size() != 0) && !m_txflush;
    end

    always @(negedge clk) begin
        if (rx_mon) begin
            logic [7:0] e;
            e = rxq.pop_front();
            chk("R5 rx byte order (R7 when looped)", rx_rdata, e);
        end
        if (tx_mon) begin
            logic [7:0] e;
            e = txq.pop_front();
            chk("R5 tx byte order", tx_rdata, e);
            if (m_loop && !m_rxflush && rxq.size() < 16) rxq.push_back(e);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, saved;
        int rl [4] = '{1, 4, 8, 14};
        @(negedge clk); @(negedge clk);
        rd_reg(1'b0, v);
        chk("R1 control after reset", v, 8'h00);
        chk("R5 levels after reset", {tx_level, rx_level}, 0);
        rst_n = 1'b1;
        idle(2);
        rd_reg(1'b1, v);
        chk("R10 R3 status after reset", v, 8'h02);

        wr_reg(1'b0, 8'hA8);
        rd_reg(1'b0, v);
        chk("R1 readback incl bit3", v, 8'hA8);
        wr_reg(1'b0, 8'h57);
        rd_reg(1'b0, v);
        chk("R1 readback second pattern", v, 8'h57);
        standby = 1'b1; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'hFF;
        @(negedge clk);
        standby = 1'b0; reg_wr = 1'b0;
        m_loop = 0; m_rxflush = 0; m_txflush = 0;
        rd_reg(1'b0, v);
        chk("R1 standby clears over write", v, 8'h00);

        // Receive thresholds
        for (int c = 0; c < 4; c++) begin
            wr_reg(1'b0, 8'((c << 6) | 2));
            wr_reg(1'b0, 8'(c << 6));
            wr_reg(1'b1, 8'h06);
            idle(1);
            rd_reg(1'b1, v);
            chk("R4 rx flag clear accepted", v[0], 0);
            for (int i = 0; i < rl[c] - 1; i++) push_rx(8'(c * 16 + i));
            idle(2);
            rd_reg(1'b1, v);
            chk("R2 rx flag below threshold", v[0], 0);
            push_rx(8'(c * 16 + 15));
            idle(2);
            rd_reg(1'b1, v);
            chk("R2 rx flag at threshold", v[0], 1);
            chk("R5 rx level", rx_level, rl[c]);
            wr_reg(1'b1, 8'h06);
            idle(1);
            rd_reg(1'b1, v);
            chk("R4 clear refused", v[0], 1);
            for (int i = 0; i < rl[c]; i++) pop_rx();
            idle(2);
            rd_reg(1'b1, v);
            chk("R4 sticky after drain", v[0], 1);
            wr_reg(1'b1, 8'h06);
            idle(1);
            rd_reg(1'b1, v);
            chk("R4 clear after drain", v[0], 0);
        end

        // Transmit thresholds
        for (int c = 0; c < 4; c++) begin
            int tl;
            tl = 8 >> c;
            wr_reg(1'b0, 8'((c << 4) | 4));
            wr_reg(1'b0, 8'(c << 4));
            for (int i = 0; i < 16; i++) push_tx(8'(8'h40 + c * 16 + i));
            idle(2);
            chk("R5 tx level full", tx_level, 16);
            wr_reg(1'b1, 8'h05);
            idle(1);
            rd_reg(1'b1, v);
            chk("R3 tx flag clear above threshold", v[1], 0);
            for (int i = 0; i < 16 - tl - 1; i++) pop_tx();
            idle(2);
            rd_reg(1'b1, v);
            chk("R3 tx flag one above threshold", v[1], 0);
            pop_tx();
            idle(2);
            rd_reg(1'b1, v);
            chk("R3 tx flag at threshold", v[1], 1);
            for (int i = 0; i < tl; i++) pop_tx();
            idle(2);
        end

        // Overrun
        wr_reg(1'b0, 8'h02);
        wr_reg(1'b0, 8'h00);
        for (int i = 0; i < 17; i++) push_rx(8'(8'h90 + i));
        idle(2);
        chk("R8 rx level capped", rx_level, 16);
        rd_reg(1'b1, v);
        chk("R8 overrun set", v[2], 1);
        for (int i = 0; i < 16; i++) pop_rx();
        idle(2);
        wr_reg(1'b1, 8'h03);
        idle(1);
        rd_reg(1'b1, v);
        chk("R8 overrun cleared", v[2], 0);

        // Pops from empty queues
        saved = rx_rdata;
        pop_rx();
        idle(1);
        chk("R9 rx data after empty pop", rx_rdata, saved);
        chk("R9 rx level after empty pop", rx_level, 0);
        saved = tx_rdata;
        pop_tx();
        idle(1);
        chk("R9 tx data after empty pop", tx_rdata, saved);
        chk("R9 tx level after empty pop", tx_level, 0);

        // Flush
        push_rx(8'h11); push_rx(8'h12);
        wr_reg(1'b0, 8'h02);
        idle(1);
        chk("R6 rx flush empties", rx_level, 0);
        push_rx(8'h13); push_rx(8'h14); push_rx(8'h15);
        idle(2);
        chk("R6 rx push ignored while flushing", rx_level, 0);
        wr_reg(1'b0, 8'h04);
        push_tx(8'h21); push_tx(8'h22);
        idle(2);
        chk("R6 tx push ignored while flushing", tx_level, 0);
        wr_reg(1'b0, 8'h00);

        // Loopback
        wr_reg(1'b0, 8'h01);
        push_tx(8'hC1); push_tx(8'hC2); push_tx(8'hC3);
        push_rx(8'hEE);
        idle(2);
        chk("R7 external rx push ignored", rx_level, 0);
        for (int i = 0; i < 3; i++) pop_tx();
        idle(3);
        chk("R7 looped bytes in rx queue", rx_level, 3);
        for (int i = 0; i < 3; i++) pop_rx();
        idle(2);
        chk("R7 rx drained", rx_level, 0);
        wr_reg(1'b0, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule